// File: doc/BRIEF.md
# Serial command and diagnosis port for a dual low-side switch

This block is the serial slave port of a two-channel power switch controller. A host selects it with an active-low chip select and clocks an 8-bit frame. The frame carries a command on the serial input while the current diagnosis byte, supplied in parallel by the fault logic, leaves on the serial output, most significant bit first. When chip select is released, a frame of exactly eight bits is decoded. A valid command updates the configuration fields, the serial channel enable bits or the sleep state, and raises a one-cycle request that tells the fault logic to clear its record.

All three serial pins are oversampled by the system clock through a synchronizer, and their edges are found inside the clock domain. The serial output comes as a data bit together with an output-enable, so the pad ring can build the three-state driver. In sleep state the port answers only the wake-up command.

Top module: `sw_spi_ctrl`

## Requirements
- R1: On a chip-select falling edge, `diag_in` is captured and `sdo_oe` rises, with `sdo` showing bit 7 of the captured byte. In sleep state the captured byte is 8'h00 instead.
- R2: While selected, `sdi` is sampled on each `sclk` falling edge, MSB first. After the k-th falling edge, the following `sclk` rising edge advances `sdo` to bit 7-k of the captured byte.
- R3: While chip select is high, `sclk` and `sdi` have no effect, `sdo_oe` is 0 and `sdo` is 0.
- R4: On chip-select rising, a valid command produces exactly one `diag_clr` pulse. Opcode 001 (the top three bits) is not a command: nothing changes and no pulse is issued.
- R5: Opcode 011 sets `cfg_io_spi` from bit 4, `cfg_in_mode` from bits 3:2 (00 parallel, 01 OR, 10 AND, 11 serial only) and `cfg_pin_fn` from bits 1:0 (00 fault, 01 sense ch1, 10 sense ch2, 11 sense sum).
- R6: Opcode 010 sets `cfg_ilim[1]` from bit 4, `cfg_ilim[0]` from bit 3, `cfg_latch` from bit 2, `cfg_slew[1]` from bit 1 and `cfg_slew[0]` from bit 0.
- R7: Opcode 111 sets `ch_serial[1]` from bit 1 and `ch_serial[0]` from bit 0. Opcode 000 changes no register but is valid.
- R8: Opcode 100 returns every configuration field and both channel bits to 0.
- R9: Opcode 101 clears the channel bits, keeps the configuration and sets `sleep_mode`. In sleep state every opcode except 110 is ignored and issues no pulse. Opcode 110 clears `sleep_mode`.
- R10: A frame with any number of clock falling edges other than 8 is ignored and issues no pulse.
- R11: After reset, all configuration fields, channel bits, `sleep_mode`, `diag_clr` and `sdo_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| diag_in | input | 8 | Parallel diagnosis byte from the fault logic |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Output enable for the serial data driver |
| cfg_io_spi | output | 1 | 1: serial readout with fault/sense pin, 0: per-channel status pins |
| cfg_in_mode | output | 2 | Channel control source select |
| cfg_pin_fn | output | 2 | Function of the multi-purpose pin |
| cfg_ilim | output | 2 | Per-channel overload mode, 1 = limiting, 0 = shut-off |
| cfg_latch | output | 1 | Overtemperature mode, 1 = latching, 0 = autorestart |
| cfg_slew | output | 2 | Per-channel slew select, 1 = slow |
| ch_serial | output | 2 | Serial on/off bits of the channels |
| sleep_mode | output | 1 | Low-power state flag |
| diag_clr | output | 1 | One-cycle request to clear the diagnosis record |

## Verification
Directed frames cover each opcode with distinct bit patterns, so that a swapped or shifted field shows up in the configuration outputs. They also cover the no-command code, which separates a valid frame from an ignored one by the clear pulse alone. Seven- and nine-bit frames separate the length check from the opcode check. A sleep sequence shows that the channel bits clear while the configuration stays, that the shifted-out byte reads zero, and that only wake-up is accepted. Random commands, lengths and diagnosis bytes then mix all of these, with the serial output compared bit by bit against the diagnosis byte given at chip-select fall.

// File: rtl/sw_spi_pkg.sv
package sw_spi_pkg;

    localparam int OPC_W = 3;

    typedef enum logic [OPC_W-1:0] {
        OPC_DIAG   = 3'b000,
        OPC_NOP    = 3'b001,
        OPC_OUTCFG = 3'b010,
        OPC_IOCFG  = 3'b011,
        OPC_RESET  = 3'b100,
        OPC_SLEEP  = 3'b101,
        OPC_WAKE   = 3'b110,
        OPC_CHAN   = 3'b111
    } opc_e;

    typedef struct packed {
        logic       io_spi;
        logic [1:0] in_mode;
        logic [1:0] pin_fn;
        logic [1:0] ilim;
        logic       latch;
        logic [1:0] slew;
    } cfg_t;

    localparam cfg_t CFG_DEFAULT = '0;

endpackage

// File: rtl/sw_spi_sync.sv
module sw_spi_sync #(
    parameter int               WIDTH     = 3,
    parameter int               STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] chain_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= RESET_VAL;
                else        chain_q[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q[g] <= RESET_VAL;
                else        chain_q[g] <= chain_q[g-1];
            end
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/sw_spi_shifter.sv
module sw_spi_shifter #(
    parameter int FRAME_BITS = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_s,
    input  logic                  sclk_s,
    input  logic                  sdi_s,
    input  logic [FRAME_BITS-1:0] diag_in,
    input  logic                  sleep_i,
    output logic                  sdo,
    output logic                  sdo_oe,
    output logic                  frame_done,
    output logic                  frame_len_ok,
    output logic [FRAME_BITS-1:0] frame_byte
);

    localparam int CNT_W   = $clog2(FRAME_BITS) + 1;
    localparam int CNT_MAX = (1 << CNT_W) - 1;

    typedef struct packed {
        logic                  cs_prev;
        logic                  sclk_prev;
        logic [FRAME_BITS-1:0] rx;
        logic [FRAME_BITS-1:0] tx;
        logic [CNT_W-1:0]      cnt;
        logic                  done;
        logic                  len_ok;
        logic [FRAME_BITS-1:0] byte_out;
    } shf_t;

    shf_t st_d, st_q;
    logic cs_fall, cs_rise, sclk_rise, sclk_fall;

    always_comb begin
        st_d           = st_q;
        st_d.done      = 1'b0;
        st_d.cs_prev   = cs_s;
        st_d.sclk_prev = sclk_s;
        cs_fall   = st_q.cs_prev & ~cs_s;
        cs_rise   = ~st_q.cs_prev & cs_s;
        sclk_rise = ~st_q.sclk_prev & sclk_s & ~cs_s & ~st_q.cs_prev;
        sclk_fall = st_q.sclk_prev & ~sclk_s & ~cs_s & ~st_q.cs_prev;
        if (cs_fall) begin
            st_d.tx  = sleep_i ? '0 : diag_in;
            st_d.rx  = '0;
            st_d.cnt = '0;
        end else begin
            if (sclk_fall) begin
                st_d.rx = {st_q.rx[FRAME_BITS-2:0], sdi_s};
                if (st_q.cnt != CNT_W'(CNT_MAX)) st_d.cnt = st_q.cnt + 1'b1;
            end
            if (sclk_rise && st_q.cnt != '0) begin
                st_d.tx = {st_q.tx[FRAME_BITS-2:0], 1'b0};
            end
        end
        if (cs_rise) begin
            st_d.done     = 1'b1;
            st_d.len_ok   = (st_q.cnt == CNT_W'(FRAME_BITS));
            st_d.byte_out = st_q.rx;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
            st_q.cs_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sdo_oe       = ~cs_s;
    assign sdo          = ~cs_s & st_q.tx[FRAME_BITS-1];
    assign frame_done   = st_q.done;
    assign frame_len_ok = st_q.len_ok;
    assign frame_byte   = st_q.byte_out;

    // R1: capture of the diagnosis byte at select
    p_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cs_prev && !cs_s && !sleep_i) |=> (st_q.tx == $past(diag_in)));

    // R3: deselected port keeps its receive state
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && st_q.cs_prev) |=> ($stable(st_q.rx) && $stable(st_q.cnt)));

endmodule

// File: rtl/sw_spi_regs.sv
module sw_spi_regs
    import sw_spi_pkg::*;
#(
    parameter int FRAME_BITS = 8,
    parameter int NCH        = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frame_done,
    input  logic                  frame_len_ok,
    input  logic [FRAME_BITS-1:0] frame_byte,
    output cfg_t                  cfg_o,
    output logic [NCH-1:0]        ch_o,
    output logic                  sleep_o,
    output logic                  diag_clr_o
);

    typedef struct packed {
        cfg_t           cfg;
        logic [NCH-1:0] ch;
        logic           sleep;
        logic           clr;
    } reg_t;

    reg_t rg_d, rg_q;
    opc_e opc;
    logic accept;

    assign opc    = opc_e'(frame_byte[FRAME_BITS-1 -: OPC_W]);
    assign accept = frame_done & frame_len_ok;

    always_comb begin
        rg_d     = rg_q;
        rg_d.clr = 1'b0;
        if (accept) begin
            if (rg_q.sleep) begin
                if (opc == OPC_WAKE) begin
                    rg_d.sleep = 1'b0;
                    rg_d.clr   = 1'b1;
                end
            end else begin
                unique case (opc)
                    OPC_DIAG: rg_d.clr = 1'b1;
                    OPC_NOP:  rg_d.clr = 1'b0;
                    OPC_OUTCFG: begin
                        rg_d.cfg.ilim  = frame_byte[4:3];
                        rg_d.cfg.latch = frame_byte[2];
                        rg_d.cfg.slew  = frame_byte[1:0];
                        rg_d.clr       = 1'b1;
                    end
                    OPC_IOCFG: begin
                        rg_d.cfg.io_spi  = frame_byte[4];
                        rg_d.cfg.in_mode = frame_byte[3:2];
                        rg_d.cfg.pin_fn  = frame_byte[1:0];
                        rg_d.clr         = 1'b1;
                    end
                    OPC_RESET: begin
                        rg_d.cfg = CFG_DEFAULT;
                        rg_d.ch  = '0;
                        rg_d.clr = 1'b1;
                    end
                    OPC_SLEEP: begin
                        rg_d.ch    = '0;
                        rg_d.sleep = 1'b1;
                        rg_d.clr   = 1'b1;
                    end
                    OPC_WAKE: rg_d.clr = 1'b1;
                    OPC_CHAN: begin
                        rg_d.ch  = frame_byte[NCH-1:0];
                        rg_d.clr = 1'b1;
                    end
                    default: rg_d.clr = 1'b0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rg_q <= '0;
        else        rg_q <= rg_d;
    end

    assign cfg_o      = rg_q.cfg;
    assign ch_o       = rg_q.ch;
    assign sleep_o    = rg_q.sleep;
    assign diag_clr_o = rg_q.clr;

    // R4: clear request is a single-cycle pulse
    p_clr_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rg_q.clr |=> !rg_q.clr);

    // R10: wrong-length frame leaves every register alone
    p_bad_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !frame_len_ok) |=>
            ($stable(rg_q.cfg) && $stable(rg_q.ch) && !rg_q.clr));

    // R9: in sleep, only wake-up has any effect
    p_sleep_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rg_q.sleep && !(accept && opc == OPC_WAKE)) |=>
            ($stable(rg_q.cfg) && $stable(rg_q.ch) && !rg_q.clr));

    // R9: channels stay off while asleep
    p_sleep_ch_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rg_q.sleep |-> (rg_q.ch == '0));

endmodule

// File: rtl/sw_spi_ctrl.sv
module sw_spi_ctrl
    import sw_spi_pkg::*;
#(
    parameter int FRAME_BITS  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cs_n,
    input  logic                  sclk,
    input  logic                  sdi,
    input  logic [FRAME_BITS-1:0] diag_in,
    output logic                  sdo,
    output logic                  sdo_oe,
    output logic                  cfg_io_spi,
    output logic [1:0]            cfg_in_mode,
    output logic [1:0]            cfg_pin_fn,
    output logic [1:0]            cfg_ilim,
    output logic                  cfg_latch,
    output logic [1:0]            cfg_slew,
    output logic [1:0]            ch_serial,
    output logic                  sleep_mode,
    output logic                  diag_clr
);

    localparam int NCH = 2;

    logic [2:0]            pins_s;
    logic                  frame_done, frame_len_ok, sleep_w;
    logic [FRAME_BITS-1:0] frame_byte;
    cfg_t                  cfg_w;

    sw_spi_sync #(
        .WIDTH     (3),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n, sclk, sdi}),
        .q     (pins_s)
    );

    sw_spi_shifter #(.FRAME_BITS(FRAME_BITS)) u_shf (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_s         (pins_s[2]),
        .sclk_s       (pins_s[1]),
        .sdi_s        (pins_s[0]),
        .diag_in      (diag_in),
        .sleep_i      (sleep_w),
        .sdo          (sdo),
        .sdo_oe       (sdo_oe),
        .frame_done   (frame_done),
        .frame_len_ok (frame_len_ok),
        .frame_byte   (frame_byte)
    );

    sw_spi_regs #(.FRAME_BITS(FRAME_BITS), .NCH(NCH)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_done   (frame_done),
        .frame_len_ok (frame_len_ok),
        .frame_byte   (frame_byte),
        .cfg_o        (cfg_w),
        .ch_o         (ch_serial),
        .sleep_o      (sleep_w),
        .diag_clr_o   (diag_clr)
    );

    assign cfg_io_spi  = cfg_w.io_spi;
    assign cfg_in_mode = cfg_w.in_mode;
    assign cfg_pin_fn  = cfg_w.pin_fn;
    assign cfg_ilim    = cfg_w.ilim;
    assign cfg_latch   = cfg_w.latch;
    assign cfg_slew    = cfg_w.slew;
    assign sleep_mode  = sleep_w;

    // R3: no serial drive while deselected
    p_sdo_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> !sdo);

endmodule

// File: tb/tb_sw_spi_ctrl.sv
module tb_sw_spi_ctrl;

    localparam int HALF = 6;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic [7:0] diag_in = 8'h00;
    logic       sdo, sdo_oe, cfg_io_spi, cfg_latch, sleep_mode, diag_clr;
    logic [1:0] cfg_in_mode, cfg_pin_fn, cfg_ilim, cfg_slew, ch_serial;

    always #10 clk = ~clk;

    sw_spi_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .diag_in(diag_in), .sdo(sdo), .sdo_oe(sdo_oe),
        .cfg_io_spi(cfg_io_spi), .cfg_in_mode(cfg_in_mode),
        .cfg_pin_fn(cfg_pin_fn), .cfg_ilim(cfg_ilim), .cfg_latch(cfg_latch),
        .cfg_slew(cfg_slew), .ch_serial(ch_serial), .sleep_mode(sleep_mode),
        .diag_clr(diag_clr)
    );

    int n_chk = 0, n_bad = 0, clr_cnt = 0, cyc = 0;
    logic       m_io = 0, m_latch = 0, m_sleep = 0;
    logic [1:0] m_in = 0, m_pin = 0, m_ilim = 0, m_slew = 0, m_ch = 0;

    always @(posedge clk) begin
        if (rst_n && diag_clr) clr_cnt <= clr_cnt + 1;
        cyc <= cyc + 1;
        if (cyc == 190000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wclk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_regs(string req);
        chk(req, "cfg_io_spi", 16'(cfg_io_spi), 16'(m_io));
        chk(req, "cfg_in_mode", 16'(cfg_in_mode), 16'(m_in));
        chk(req, "cfg_pin_fn", 16'(cfg_pin_fn), 16'(m_pin));
        chk(req, "cfg_ilim", 16'(cfg_ilim), 16'(m_ilim));
        chk(req, "cfg_latch", 16'(cfg_latch), 16'(m_latch));
        chk(req, "cfg_slew", 16'(cfg_slew), 16'(m_slew));
        chk(req, "ch_serial", 16'(ch_serial), 16'(m_ch));
        chk(req, "sleep_mode", 16'(sleep_mode), 16'(m_sleep));
        chk("R3", "sdo_oe idle", 16'(sdo_oe), 16'h0);
        chk("R3", "sdo idle", 16'(sdo), 16'h0);
    endtask

    // model of the command decode, from the requirements
    function automatic logic model_apply(logic [7:0] c, int nb);
        logic [2:0] op = c[7:5];
        if (nb != 8) return 1'b0;                      // R10
        if (m_sleep) begin                             // R9
            if (op == 3'b110) begin m_sleep = 0; return 1'b1; end
            return 1'b0;
        end
        case (op)
            3'b000: return 1'b1;                       // R7
            3'b001: return 1'b0;                       // R4
            3'b010: begin m_ilim = c[4:3]; m_latch = c[2]; m_slew = c[1:0]; return 1'b1; end // R6
            3'b011: begin m_io = c[4]; m_in = c[3:2]; m_pin = c[1:0]; return 1'b1; end       // R5
            3'b100: begin m_io = 0; m_in = 0; m_pin = 0; m_ilim = 0; m_latch = 0;
                          m_slew = 0; m_ch = 0; return 1'b1; end                             // R8
            3'b101: begin m_ch = 0; m_sleep = 1; return 1'b1; end                            // R9
            3'b110: return 1'b1;
            default: begin m_ch = c[1:0]; return 1'b1; end                                   // R7
        endcase
    endfunction

    task automatic frame(string req, logic [7:0] cmd, int nbits, logic [7:0] diag);
        logic [7:0] exp_so = m_sleep ? 8'h00 : diag;   // R1
        int         c0;
        logic       v;
        diag_in = diag;
        wclk(2);
        cs_n = 1'b0;
        wclk(HALF);
        chk("R1", "sdo_oe after select", 16'(sdo_oe), 16'h1);
        for (int i = 0; i < nbits; i++) begin
            sdi  = (i < 8) ? cmd[7-i] : 1'b0;
            wclk(1);
            sclk = 1'b1;
            wclk(HALF);
            if (i < 8) chk(i == 0 ? "R1" : "R2", "sdo bit", 16'(sdo), 16'(exp_so[7-i]));
            sclk = 1'b0;
            wclk(HALF);
        end
        c0   = clr_cnt;
        cs_n = 1'b1;
        wclk(10);
        v = model_apply(cmd, nbits);
        chk("R4", "diag_clr pulses", 16'(clr_cnt - c0), 16'(v));
        check_regs(req);
        diag_in = 8'h00;
        wclk(4);
    endtask

    initial begin
        void'($urandom(32'd5021));
        wclk(3);
        check_regs("R11");
        chk("R11", "diag_clr", 16'(diag_clr), 16'h0);
        rst_n = 1'b1;
        wclk(4);
        // R3: clock and data toggling while deselected
        for (int i = 0; i < 6; i++) begin
            sdi = i[0]; sclk = ~sclk; wclk(HALF);
            chk("R3", "sdo_oe deselected", 16'(sdo_oe), 16'h0);
        end
        sclk = 1'b0; wclk(4);
        check_regs("R3");
        frame("R5", 8'h7A, 8, 8'hA5);   // io cfg: spi=1 in=10 pin=10
        frame("R5", 8'h65, 8, 8'h3C);   // io cfg: spi=0 in=01 pin=01
        frame("R6", 8'h55, 8, 8'hC3);   // out cfg: ilim=10 latch=1 slew=01
        frame("R6", 8'h4A, 8, 8'h81);   // out cfg: ilim=01 latch=0 slew=10
        frame("R7", 8'hE3, 8, 8'h7E);
        frame("R7", 8'h1F, 8, 8'h5A);   // diag only
        frame("R4", 8'h3F, 8, 8'hF0);   // no command
        frame("R10", 8'hE0, 7, 8'h0F);
        frame("R10", 8'hE0, 9, 8'h96);
        frame("R9", 8'hA0, 8, 8'h69);   // sleep
        frame("R9", 8'hE3, 8, 8'hFF);   // ignored, SO reads zero
        frame("R9", 8'h80, 8, 8'hFF);   // reset ignored
        frame("R9", 8'hC0, 8, 8'h11);   // wake
        frame("R7", 8'hE2, 8, 8'h22);
        frame("R8", 8'h80, 8, 8'h44);
        for (int k = 0; k < 150; k++) begin
            int r = $urandom % 10;
            int nb = (r == 0) ? 7 : (r == 1) ? 9 : 8;
            frame("R2", 8'($urandom), nb, 8'($urandom));
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule